// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a 16-bit down-counting interval timer behind three 16-bit registers: control/status, modulus and a read-only live count. The bus selects a register with a two-bit word index. Word 0 is the control register at byte offset 0. Word 1 is the modulus at byte offset 2. Word 2 is the count at byte offset 4. Reads are combinational, and writes take effect at the clock edge on which `bus_wr` is high.

The counter steps down once per tick of a divided clock. The base rate is half the system clock, and a 4-bit power-of-two prescaler divides it further. When the counter runs out, it either reloads from the modulus register or restarts from full scale, and it raises a sticky interrupt flag. Software clears the flag by writing a one to it.

The interrupt line is the flag gated by an enable bit. A modulus write clears the flag, and when the overwrite bit is set it also forces the new value into the running count. A control write that changes only the interrupt-enable bit, or only clears the flag, leaves the count and the prescaler phase alone. Any other control write restarts the count.

Top module: `pit_timer`

## Requirements
- R1: After reset, control reads 0x0000, modulus reads 0xFFFF, count reads 0xFFFF, and `irq` is 0.
- R2: Control bits are: bit0 run enable, bit1 reload select, bit2 interrupt flag, bit3 interrupt enable, bit4 overwrite, bit5 and bit6 stored with no effect on the timer, bits 11:8 the prescaler code P. Bits 15:12 always read 0. Word index 3 reads 0.
- R3: While enabled, the count drops by one every 2^(P+1) clock cycles. After a restarting control write, the first step comes 2^(P+1) cycles after that write's edge.
- R4: A step taken at count 1 (or 0) sets the flag and loads the limit instead of decrementing. The limit is the modulus when reload select is 1, and 0xFFFF when it is 0.
- R5: `irq` is 1 exactly when both the flag and interrupt enable are 1.
- R6: Writing 1 to control bit2 clears the flag. Writing 0 to it leaves the flag unchanged.
- R7: A control write whose bits other than bit2 and bit3 equal the stored ones leaves the count and the prescaler phase undisturbed.
- R8: Any other control write loads the count with the new limit and resets the prescaler.
- R9: Any modulus write clears the flag.
- R10: A modulus write while overwrite is 1 loads the written value into the count on that edge, whatever reload select is.
- R11: Word 2 reads the live count. Writes to word 2 change no register.
- R12: While run enable is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 2 | Register select (0 control, 1 modulus, 2 count) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a control write that lands mid-period and changes only the interrupt enable. To be sure it did not disturb the count, the divider phase has to survive the write, and that can only be seen from the ports through when later steps occur. The bench starts a count with a known restart edge and tracks elapsed edges through the write. It then checks the count against the arithmetic expected value on both sides of the write, and contrasts this with a prescaler change that must restart. A sweep over prescaler codes 0 to 4 and several moduli checks every cycle of the step timing and the flag around expiry.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 4;
    localparam int DIV_W  = 2 ** PRE_W;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             doze;
        logic             dbg;
        logic             ovw;
        logic             ie;
        logic             flag;
        logic             rld;
        logic             en;
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_MOD  = 2'd1,
        REG_CNT  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = c.en;
        w[1] = c.rld;
        w[2] = c.flag;
        w[3] = c.ie;
        w[4] = c.ovw;
        w[5] = c.dbg;
        w[6] = c.doze;
        w[8 +: PRE_W] = c.pre;
        return w;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en   = w[0];
        c.rld  = w[1];
        c.flag = w[2];
        c.ie   = w[3];
        c.ovw  = w[4];
        c.dbg  = w[5];
        c.doze = w[6];
        c.pre  = w[8 +: PRE_W];
        return c;
    endfunction

    // True when a control write changes anything besides the interrupt bits.
    function automatic logic ctrl_restarts(input ctrl_t cur, input ctrl_t nxt);
        return (cur.en != nxt.en) || (cur.rld != nxt.rld) || (cur.ovw != nxt.ovw)
            || (cur.dbg != nxt.dbg) || (cur.doze != nxt.doze) || (cur.pre != nxt.pre);
    endfunction

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  mod_q,
    output logic              restart,
    output logic [CNT_W-1:0]  restart_val,
    output logic              ovw_load
);

    ctrl_t wr_c;
    ctrl_t ctrl_d;
    logic  wr_ctrl;
    logic  wr_mod;

    always_comb begin
        wr_c        = ctrl_unpack(wdata);
        wr_ctrl     = wr && (sel == REG_CTRL);
        wr_mod      = wr && (sel == REG_MOD);
        restart     = wr_ctrl && ctrl_restarts(ctrl_q, wr_c);
        restart_val = wr_c.rld ? mod_q : {CNT_W{1'b1}};
        ovw_load    = wr_mod && ctrl_q.ovw;
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d      = wr_c;
            ctrl_d.flag = ctrl_q.flag & ~wr_c.flag;
        end
        if (wr_mod) begin
            ctrl_d.flag = 1'b0;
        end
        if (expire) begin
            ctrl_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mod_q  <= {CNT_W{1'b1}};
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_mod) begin
                mod_q <= wdata[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRE_W-1:0] pre,
    input  logic             restart,
    output logic             step
);

    localparam logic [DIV_W-1:0] ONES = {DIV_W{1'b1}};

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_max;

    always_comb begin
        // 2^(pre+1) - 1: the half-rate base tick folded into the divider
        div_max = ~(ONES << (int'(pre) + 1));
        step    = en && (div_q == div_max) && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (en) begin
            div_q <= (div_q == div_max) ? '0 : div_q + 1'b1;
        end
    end

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             restart,
    input  logic [CNT_W-1:0] restart_val,
    input  logic             ovw_load,
    input  logic [CNT_W-1:0] ovw_val,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    logic at_end;

    always_comb begin
        at_end = (cnt_q <= CNT_W'(1));
        expire = step && at_end && !restart && !ovw_load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= {CNT_W{1'b1}};
        end else if (restart) begin
            cnt_q <= restart_val;
        end else if (ovw_load) begin
            cnt_q <= ovw_val;
        end else if (step) begin
            cnt_q <= at_end ? limit : cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    reg_sel_e         sel;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] restart_val;
    logic [CNT_W-1:0] limit;
    logic             restart;
    logic             ovw_load;
    logic             step;
    logic             expire;

    assign sel   = reg_sel_e'(bus_word);
    assign limit = ctrl_q.rld ? mod_q : {CNT_W{1'b1}};
    assign irq   = ctrl_q.flag & ctrl_q.ie;

    pit_regs i_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (bus_wr),
        .sel         (sel),
        .wdata       (bus_wdata),
        .expire      (expire),
        .ctrl_q      (ctrl_q),
        .mod_q       (mod_q),
        .restart     (restart),
        .restart_val (restart_val),
        .ovw_load    (ovw_load)
    );

    pit_prescaler i_prescaler (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.en),
        .pre     (ctrl_q.pre),
        .restart (restart),
        .step    (step)
    );

    pit_counter i_counter (
        .clk         (clk),
        .rst         (rst),
        .step        (step),
        .restart     (restart),
        .restart_val (restart_val),
        .ovw_load    (ovw_load),
        .ovw_val     (bus_wdata[CNT_W-1:0]),
        .limit       (limit),
        .cnt_q       (cnt_q),
        .expire      (expire)
    );

    always_comb begin
        unique case (sel)
            REG_CTRL: bus_rdata = ctrl_pack(ctrl_q);
            REG_MOD:  bus_rdata = DATA_W'(mod_q);
            REG_CNT:  bus_rdata = DATA_W'(cnt_q);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pit_checker.sv
module pit_checker
    import pit_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [1:0]       bus_word,
    input logic [15:0]      bus_wdata,
    input logic             irq,
    input ctrl_t            ctrl_q,
    input logic [CNT_W-1:0] mod_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             step,
    input logic             expire
);

    a_r3_step_decrements: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q > CNT_W'(1) && !bus_wr) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r4_expiry_sets_flag: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctrl_q.flag);

    a_r5_irq_on_expiry: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q.ie && !bus_wr) |=> irq);

    a_r9_mod_write_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word == 2'd1 && !expire) |=> (!ctrl_q.flag && !irq));

    a_r10_overwrite_loads: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word == 2'd1 && ctrl_q.ovw) |=> (cnt_q == $past(bus_wdata)));

    a_r11_count_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word == 2'd2 && !expire) |=> ($stable(mod_q) && $stable(ctrl_q)));

    a_r12_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !bus_wr) |=> $stable(cnt_q));

endmodule

bind pit_timer pit_checker i_pit_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .ctrl_q    (ctrl_q),
    .mod_q     (mod_q),
    .cnt_q     (cnt_q),
    .step      (step),
    .expire    (expire)
);

// File: tb/test_pit_timer.sv
module test_pit_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_word = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pit_timer i_pit_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] w, output logic [15:0] v);
        bus_word = w;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] w, input logic [15:0] d);
        bus_word  = w;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        tick(3);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
        rd(2'd1, v); chk("R1 mod", v, 16'hFFFF);
        rd(2'd2, v); chk("R1 count", v, 16'hFFFF);
        chk("R1 irq", {15'b0, irq}, 16'h0000);

        // R2 field layout and read-back masking
        wr(2'd0, 16'hFF72);
        rd(2'd0, v); chk("R2 ctrl readback", v, 16'h0F72);
        rd(2'd3, v); chk("R2 unused word", v, 16'h0000);
        wr(2'd0, 16'h0000);

        // R3 R4 R8 sweep over prescaler codes and moduli
        for (int pre = 0; pre <= 4; pre++) begin
            for (int li = 0; li < 4; li++) begin
                int n;
                int lim;
                n   = 2 << pre;
                lim = (li == 3) ? 5 : li + 1;
                wr(2'd0, 16'h0004);
                wr(2'd1, 16'(lim));
                wr(2'd0, 16'h0003 | 16'(pre << 8));
                rd(2'd2, v); chk("R8 restart loads limit", v, 16'(lim));
                for (int k = 1; k <= (lim + 1) * n; k++) begin
                    tick(1);
                    rd(2'd2, v);
                    chk("R3 step timing", v, 16'(lim - ((k / n) % lim)));
                    if (k == lim * n - 1 || k == lim * n) begin
                        rd(2'd0, v);
                        chk("R4 flag at expiry", {15'b0, v[2]}, {15'b0, ((k / n) >= lim)});
                    end
                end
            end
        end

        // R4 free-run wraps to full scale limit
        wr(2'd0, 16'h0004);
        wr(2'd0, 16'h0001);
        tick(1); rd(2'd2, v); chk("R4 free-run start", v, 16'hFFFF);
        tick(1); rd(2'd2, v); chk("R4 free-run step", v, 16'hFFFE);

        // R5 R6 interrupt gating and write-one-to-clear on a stopped timer
        wr(2'd1, 16'd1);
        wr(2'd0, 16'h0003);
        tick(4);
        wr(2'd0, 16'h0000);
        rd(2'd0, v); chk("R6 flag kept on zero write", {15'b0, v[2]}, 16'h0001);
        chk("R5 irq off without enable", {15'b0, irq}, 16'h0000);
        wr(2'd0, 16'h0008);
        chk("R5 irq on", {15'b0, irq}, 16'h0001);
        wr(2'd0, 16'h0008);
        rd(2'd0, v); chk("R6 flag kept", {15'b0, v[2]}, 16'h0001);
        wr(2'd0, 16'h000C);
        rd(2'd0, v); chk("R6 flag cleared", {15'b0, v[2]}, 16'h0000);
        chk("R5 irq off after clear", {15'b0, irq}, 16'h0000);

        // R7 interrupt-only write keeps count and prescaler phase
        wr(2'd1, 16'd100);
        wr(2'd0, 16'h0003);
        tick(10);
        wr(2'd0, 16'h000B);
        rd(2'd2, v); chk("R7 count after ie write", v, 16'd95);
        tick(4);
        rd(2'd2, v); chk("R7 phase kept", v, 16'd93);
        wr(2'd0, 16'h010B);
        rd(2'd2, v); chk("R8 prescaler change restarts", v, 16'd100);

        // R9 modulus write clears flag
        wr(2'd1, 16'd1);
        wr(2'd0, 16'h0003);
        tick(4);
        wr(2'd0, 16'h0002);
        rd(2'd0, v); chk("R9 flag set before", {15'b0, v[2]}, 16'h0001);
        wr(2'd1, 16'd7);
        rd(2'd0, v); chk("R9 flag cleared", {15'b0, v[2]}, 16'h0000);

        // R10 overwrite with reload clear and set
        wr(2'd0, 16'h0010);
        wr(2'd1, 16'h1234);
        rd(2'd2, v); chk("R10 overwrite free-run", v, 16'h1234);
        wr(2'd0, 16'h0012);
        wr(2'd1, 16'h0042);
        rd(2'd2, v); chk("R10 overwrite reload", v, 16'h0042);
        rd(2'd1, v); chk("R10 new limit", v, 16'h0042);
        wr(2'd0, 16'h0002);
        wr(2'd1, 16'h0055);
        rd(2'd2, v); chk("R10 no overwrite", v, 16'h0042);

        // R11 count register writes ignored
        wr(2'd2, 16'h0000);
        rd(2'd2, v); chk("R11 count kept", v, 16'h0042);
        rd(2'd1, v); chk("R11 mod kept", v, 16'h0055);
        rd(2'd0, v); chk("R11 ctrl kept", v, 16'h0002);

        // R12 hold while disabled
        tick(20);
        rd(2'd2, v); chk("R12 hold", v, 16'h0042);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule